// File: doc/BRIEF.md
# Register Rename Stage with Free Pool

This block renames a group of instructions in one cycle. Each instruction in the group carries two logical source ids and one logical destination id. The sources are read through a speculative map. Each destination gets a fresh physical register drawn from a pool of unused ones. The block also reports the physical register that the destination named before the group, so that a later commit can give that register back to the pool.

Within a group, lane 0 is the oldest instruction. A source that names the destination of an older lane in the same group takes that lane's new physical id instead of the map entry. The same substitution applies to the reported old mapping. Once renaming is done, only true read-after-write links remain between instructions.

A second, committed map advances on the commit port, one instruction per cycle. A flush discards all speculative state. It copies the committed map into the speculative map and rebuilds the pool as every physical register that the committed map does not hold. The default configuration has 8 logical registers, 16 physical registers and 2 lanes.

Top module: `rr_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i in both maps. Physical registers 8 to 15 form the free pool, and `req_ready` is high.
- R2: A source whose logical id matches no older lane's destination in the group returns the speculative map entry for that id.
- R3: On an accepted group, lane 0 receives the lowest-numbered free physical register and lane 1 the next lowest. The lanes never share a register.
- R4: A source of lane 1 that names lane 0's logical destination returns lane 0's newly allocated physical id.
- R5: Each lane reports the previous mapping of its destination as `rsp_old`. If lane 0 writes the same logical register, lane 1 reports lane 0's new id. After the group, the speculative map holds the youngest lane's id.
- R6: `req_ready` is low while the pool holds fewer registers than there are lanes. A group offered while `req_ready` is low changes neither map nor pool.
- R7: A commit writes `cmt_phys` into the committed map entry `cmt_dst` and returns `cmt_old` to the pool. The returned register is available from the next cycle.
- R8: In a flush cycle `req_ready` is low. On the next cycle the speculative map equals the committed map, with a commit in the same cycle already applied. The pool is then every physical register that the committed map does not hold.
- R9: A register handed out by an accepted group was free before the group and is absent from the pool afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Group of instructions offered for renaming |
| req_ready | output | 1 | Group accepted this cycle when high together with req_valid |
| req_src1 | input | WIDTH*3 | First logical source of each lane; lane l in bits [3l+2:3l] |
| req_src2 | input | WIDTH*3 | Second logical source of each lane |
| req_dst | input | WIDTH*3 | Logical destination of each lane |
| rsp_src1 | output | WIDTH*4 | Physical id of first source, lane l in bits [4l+3:4l] |
| rsp_src2 | output | WIDTH*4 | Physical id of second source |
| rsp_dst | output | WIDTH*4 | Newly allocated physical destination |
| rsp_old | output | WIDTH*4 | Previous physical mapping of each destination |
| cmt_valid | input | 1 | One instruction commits this cycle |
| cmt_dst | input | 3 | Logical destination of the committing instruction |
| cmt_phys | input | 4 | Physical register it was given at rename |
| cmt_old | input | 4 | Physical register to return to the pool |
| flush | input | 1 | Restore speculative state from committed state |

## Verification
The checker watches pool bookkeeping on every cycle. Each accepted group must take exactly one register per lane, all of them from the free set, and those registers must be gone from the pool a cycle later. A committed old register must reappear in the pool. A flush must leave exactly the unmapped count free, and `req_ready` must be low during a flush or a shortage. Only the scenarios can show the source and old-mapping values themselves: the reset map, the intra-group bypass of sources and of the old mapping, the lowest-first allocation order, an offered group leaving state untouched while stalled, and the committed-map contents coming back after a flush combined with a commit.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int RR_LOG   = 8;
  localparam int RR_PHYS  = 16;
  localparam int RR_WIDTH = 2;
  localparam int RR_LW    = $clog2(RR_LOG);
  localparam int RR_PW    = $clog2(RR_PHYS);

  typedef logic [RR_LW-1:0]   lreg_t;
  typedef logic [RR_PW-1:0]   preg_t;
  typedef logic [RR_PHYS-1:0] pmask_t;

  function automatic int free_count(pmask_t m);
    int n;
    n = 0;
    for (int i = 0; i < RR_PHYS; i++) n += int'(m[i]);
    return n;
  endfunction

  // lowest set bit wins; returns 0 when the mask is empty
  function automatic preg_t first_set(pmask_t m);
    preg_t p;
    p = '0;
    for (int i = RR_PHYS - 1; i >= 0; i--) begin
      if (m[i]) p = preg_t'(i);
    end
    return p;
  endfunction

  function automatic pmask_t one_hot(preg_t p);
    return pmask_t'(1) << p;
  endfunction

  function automatic pmask_t reset_pool();
    pmask_t m;
    for (int i = 0; i < RR_PHYS; i++) m[i] = (i >= RR_LOG);
    return m;
  endfunction
endpackage

// File: rtl/rr_map_table.sv
module rr_map_table
  import rr_pkg::*;
#(
  parameter int WIDTH = RR_WIDTH
) (
  input  logic   clk,
  input  logic   rst_n,
  input  lreg_t  rd_src1 [WIDTH],
  input  lreg_t  rd_src2 [WIDTH],
  input  lreg_t  rd_dst  [WIDTH],
  output preg_t  map_src1 [WIDTH],
  output preg_t  map_src2 [WIDTH],
  output preg_t  map_dst  [WIDTH],
  input  logic   wr_en,
  input  preg_t  wr_phys [WIDTH],
  input  logic   cmt_en,
  input  lreg_t  cmt_dst,
  input  preg_t  cmt_phys,
  input  logic   flush,
  output pmask_t arch_used_next
);
  preg_t spec_q [RR_LOG];
  preg_t arch_q [RR_LOG];
  preg_t arch_d [RR_LOG];

  always_comb begin
    for (int i = 0; i < RR_LOG; i++) arch_d[i] = arch_q[i];
    if (cmt_en) arch_d[cmt_dst] = cmt_phys;
    arch_used_next = '0;
    for (int i = 0; i < RR_LOG; i++) arch_used_next |= one_hot(arch_d[i]);
  end

  for (genvar l = 0; l < WIDTH; l++) begin : g_rd
    assign map_src1[l] = spec_q[rd_src1[l]];
    assign map_src2[l] = spec_q[rd_src2[l]];
    assign map_dst[l]  = spec_q[rd_dst[l]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RR_LOG; i++) begin
        spec_q[i] <= preg_t'(i);
        arch_q[i] <= preg_t'(i);
      end
    end else begin
      for (int i = 0; i < RR_LOG; i++) arch_q[i] <= arch_d[i];
      if (flush) begin
        for (int i = 0; i < RR_LOG; i++) spec_q[i] <= arch_d[i];
      end else if (wr_en) begin
        // ascending lane order: the youngest writer of a register wins
        for (int l = 0; l < WIDTH; l++) spec_q[rd_dst[l]] <= wr_phys[l];
      end
    end
  end
endmodule

// File: rtl/rr_free_list.sv
module rr_free_list
  import rr_pkg::*;
#(
  parameter int WIDTH = RR_WIDTH
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   alloc_en,
  output preg_t  alloc_phys [WIDTH],
  output pmask_t alloc_mask,
  output pmask_t free_mask,
  output logic   enough_free,
  input  logic   release_en,
  input  preg_t  release_phys,
  input  logic   flush,
  input  pmask_t rebuild_used
);
  pmask_t free_q;
  pmask_t free_d;
  pmask_t remain;

  always_comb begin
    remain     = free_q;
    alloc_mask = '0;
    for (int l = 0; l < WIDTH; l++) begin
      alloc_phys[l] = first_set(remain);
      alloc_mask   |= one_hot(alloc_phys[l]);
      remain       &= ~one_hot(alloc_phys[l]);
    end
  end

  assign free_mask   = free_q;
  assign enough_free = free_count(free_q) >= WIDTH;

  always_comb begin
    if (flush) begin
      free_d = ~rebuild_used;
    end else begin
      free_d = free_q;
      if (alloc_en)   free_d &= ~alloc_mask;
      if (release_en) free_d |= one_hot(release_phys);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= reset_pool();
    else        free_q <= free_d;
  end
endmodule

// File: rtl/rr_dep_check.sv
module rr_dep_check
  import rr_pkg::*;
#(
  parameter int WIDTH = RR_WIDTH
) (
  input  lreg_t src1 [WIDTH],
  input  lreg_t src2 [WIDTH],
  input  lreg_t dst  [WIDTH],
  input  preg_t map_src1 [WIDTH],
  input  preg_t map_src2 [WIDTH],
  input  preg_t map_dst  [WIDTH],
  input  preg_t new_phys [WIDTH],
  output preg_t out_src1 [WIDTH],
  output preg_t out_src2 [WIDTH],
  output preg_t out_old  [WIDTH]
);
  for (genvar l = 0; l < WIDTH; l++) begin : g_lane
    always_comb begin
      out_src1[l] = map_src1[l];
      out_src2[l] = map_src2[l];
      out_old[l]  = map_dst[l];
      // older lanes in ascending order so the nearest older writer wins
      for (int j = 0; j < l; j++) begin
        if (dst[j] == src1[l]) out_src1[l] = new_phys[j];
        if (dst[j] == src2[l]) out_src2[l] = new_phys[j];
        if (dst[j] == dst[l])  out_old[l]  = new_phys[j];
      end
    end
  end
endmodule

// File: rtl/rr_rename.sv
module rr_rename
  import rr_pkg::*;
#(
  parameter int WIDTH = RR_WIDTH,
  localparam int LW = RR_LW,
  localparam int PW = RR_PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [WIDTH*LW-1:0] req_src1,
  input  logic [WIDTH*LW-1:0] req_src2,
  input  logic [WIDTH*LW-1:0] req_dst,
  output logic [WIDTH*PW-1:0] rsp_src1,
  output logic [WIDTH*PW-1:0] rsp_src2,
  output logic [WIDTH*PW-1:0] rsp_dst,
  output logic [WIDTH*PW-1:0] rsp_old,
  input  logic            cmt_valid,
  input  logic [LW-1:0]   cmt_dst,
  input  logic [PW-1:0]   cmt_phys,
  input  logic [PW-1:0]   cmt_old,
  input  logic            flush
);
  lreg_t  src1_l [WIDTH];
  lreg_t  src2_l [WIDTH];
  lreg_t  dst_l  [WIDTH];
  preg_t  map_src1 [WIDTH];
  preg_t  map_src2 [WIDTH];
  preg_t  map_dst  [WIDTH];
  preg_t  new_phys [WIDTH];
  preg_t  fin_src1 [WIDTH];
  preg_t  fin_src2 [WIDTH];
  preg_t  fin_old  [WIDTH];
  pmask_t arch_used_next;
  pmask_t alloc_mask;
  pmask_t free_mask;
  logic   enough_free;
  logic   rename_fire;

  assign req_ready   = enough_free && !flush;
  assign rename_fire = req_valid && req_ready;

  for (genvar l = 0; l < WIDTH; l++) begin : g_flat
    assign src1_l[l] = req_src1[l*LW +: LW];
    assign src2_l[l] = req_src2[l*LW +: LW];
    assign dst_l[l]  = req_dst[l*LW +: LW];
    assign rsp_src1[l*PW +: PW] = fin_src1[l];
    assign rsp_src2[l*PW +: PW] = fin_src2[l];
    assign rsp_dst[l*PW +: PW]  = new_phys[l];
    assign rsp_old[l*PW +: PW]  = fin_old[l];
  end

  rr_map_table #(.WIDTH(WIDTH)) u_map (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_src1        (src1_l),
    .rd_src2        (src2_l),
    .rd_dst         (dst_l),
    .map_src1       (map_src1),
    .map_src2       (map_src2),
    .map_dst        (map_dst),
    .wr_en          (rename_fire),
    .wr_phys        (new_phys),
    .cmt_en         (cmt_valid),
    .cmt_dst        (cmt_dst),
    .cmt_phys       (cmt_phys),
    .flush          (flush),
    .arch_used_next (arch_used_next)
  );

  rr_free_list #(.WIDTH(WIDTH)) u_pool (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en     (rename_fire),
    .alloc_phys   (new_phys),
    .alloc_mask   (alloc_mask),
    .free_mask    (free_mask),
    .enough_free  (enough_free),
    .release_en   (cmt_valid),
    .release_phys (cmt_old),
    .flush        (flush),
    .rebuild_used (arch_used_next)
  );

  rr_dep_check #(.WIDTH(WIDTH)) u_dep (
    .src1     (src1_l),
    .src2     (src2_l),
    .dst      (dst_l),
    .map_src1 (map_src1),
    .map_src2 (map_src2),
    .map_dst  (map_dst),
    .new_phys (new_phys),
    .out_src1 (fin_src1),
    .out_src2 (fin_src2),
    .out_old  (fin_old)
  );
endmodule

// File: rtl/rr_rename_chk.sv
module rr_rename_chk
  import rr_pkg::*;
#(
  parameter int WIDTH = RR_WIDTH
) (
  input logic   clk,
  input logic   rst_n,
  input logic   rename_fire,
  input logic   req_ready,
  input logic   flush,
  input logic   cmt_valid,
  input preg_t  cmt_old,
  input pmask_t alloc_mask,
  input pmask_t free_mask
);
  // R9
  alloc_from_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rename_fire |-> ((alloc_mask & ~free_mask) == '0));

  // R3
  alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rename_fire |-> ($countones(alloc_mask) == WIDTH));

  // R9
  alloc_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rename_fire |=> ((free_mask & $past(alloc_mask)) == '0));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !flush) |=> free_mask[$past(cmt_old)]);

  // R8
  flush_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(free_mask) == RR_PHYS - RR_LOG));

  // R8
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);

  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(free_mask) < WIDTH) |-> !req_ready);
endmodule

bind rr_rename rr_rename_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rename_fire (rename_fire),
  .req_ready   (req_ready),
  .flush       (flush),
  .cmt_valid   (cmt_valid),
  .cmt_old     (cmt_old),
  .alloc_mask  (alloc_mask),
  .free_mask   (free_mask)
);

// File: tb/rr_rename_tb.sv
`timescale 1ns/1ps
module rr_rename_tb;
  localparam int W = 2;
  localparam int LW = 3;
  localparam int PW = 4;
  localparam int NL = 8;
  localparam int NP = 16;
  localparam real HALF = 4.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [W*LW-1:0] req_src1 = '0, req_src2 = '0, req_dst = '0;
  logic [W*PW-1:0] rsp_src1, rsp_src2, rsp_dst, rsp_old;
  logic cmt_valid = 1'b0;
  logic [LW-1:0] cmt_dst = '0;
  logic [PW-1:0] cmt_phys = '0, cmt_old = '0;
  logic flush = 1'b0;

  always #(HALF) clk = ~clk;

  rr_rename u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src1(req_src1), .req_src2(req_src2), .req_dst(req_dst),
    .rsp_src1(rsp_src1), .rsp_src2(rsp_src2), .rsp_dst(rsp_dst), .rsp_old(rsp_old),
    .cmt_valid(cmt_valid), .cmt_dst(cmt_dst), .cmt_phys(cmt_phys), .cmt_old(cmt_old),
    .flush(flush)
  );

  typedef struct {
    logic [W*PW-1:0] s1, s2, d, o;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the rename state
  int spec_m [NL];
  int arch_m [NL];
  bit pool_m [NP];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pool_size();
    int n = 0;
    for (int i = 0; i < NP; i++) n += int'(pool_m[i]);
    return n;
  endfunction

  function automatic int pick(input int skip);
    for (int i = 0; i < NP; i++) if (pool_m[i] && i != skip) return i;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin spec_m[i] = i; arch_m[i] = i; end
    for (int i = 0; i < NP; i++) pool_m[i] = (i >= NL);
  endtask

  task automatic model_commit_flush(input bit cv, input int cd, input int cp, input int co, input bit fl);
    if (cv) begin arch_m[cd] = cp; pool_m[co] = 1'b1; end
    if (fl) begin
      for (int i = 0; i < NP; i++) pool_m[i] = 1'b1;
      for (int i = 0; i < NL; i++) begin spec_m[i] = arch_m[i]; pool_m[arch_m[i]] = 1'b0; end
    end
  endtask

  // driver: offers one group, pushes the expected response when it should be taken
  task automatic rename(input int a1, input int a2, input int ad,
                        input int b1, input int b2, input int bd,
                        input bit fl, input string tag);
    bit rdy;
    int n0, n1;
    exp_t e;
    rdy = (pool_size() >= W) && !fl;
    n0 = pick(-1);
    n1 = pick(n0);
    req_src1 = {LW'(b1), LW'(a1)};
    req_src2 = {LW'(b2), LW'(a2)};
    req_dst  = {LW'(bd), LW'(ad)};
    req_valid = 1'b1;
    flush = fl;
    if (rdy) begin
      e.s1 = {PW'((b1 == ad) ? n0 : spec_m[b1]), PW'(spec_m[a1])};
      e.s2 = {PW'((b2 == ad) ? n0 : spec_m[b2]), PW'(spec_m[a2])};
      e.d  = {PW'(n1), PW'(n0)};
      e.o  = {PW'((bd == ad) ? n0 : spec_m[bd]), PW'(spec_m[ad])};
      e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    check(req_ready == rdy, fl ? "R8 ready during flush" : "R6 ready vs pool", int'(req_ready), int'(rdy));
    @(posedge clk); #1;
    if (rdy) begin
      spec_m[ad] = n0; spec_m[bd] = n1;
      pool_m[n0] = 1'b0; pool_m[n1] = 1'b0;
    end
    model_commit_flush(1'b0, 0, 0, 0, fl);
    req_valid = 1'b0;
    flush = 1'b0;
  endtask

  task automatic commit(input int cd, input int cp, input int co, input bit fl);
    cmt_valid = 1'b1; cmt_dst = LW'(cd); cmt_phys = PW'(cp); cmt_old = PW'(co);
    flush = fl;
    @(posedge clk); #1;
    model_commit_flush(1'b1, cd, cp, co, fl);
    cmt_valid = 1'b0;
    flush = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever a group is accepted
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R6 unexpected accept", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rsp_src1 == e.s1, {e.tag, " src1"}, int'(rsp_src1), int'(e.s1));
        check(rsp_src2 == e.s2, {e.tag, " src2"}, int'(rsp_src2), int'(e.s2));
        check(rsp_dst  == e.d,  {e.tag, " dst R3"}, int'(rsp_dst), int'(e.d));
        check(rsp_old  == e.o,  {e.tag, " old R5"}, int'(rsp_old), int'(e.o));
      end
    end
  end

  initial begin
    #(16.0 * HALF * 100000.0);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    @(posedge clk); #1;
    // R1 R2 R3: reset map read, no intra-group links
    rename(0, 1, 4, 2, 3, 5, 1'b0, "R1 R2 reset map");
    // R4 R5: lane 1 reads and rewrites lane 0's destination
    rename(4, 5, 6, 6, 7, 6, 1'b0, "R4 R5 waw bypass");
    rename(6, 0, 1, 1, 6, 2, 1'b0, "R4 src1 bypass");
    rename(0, 0, 0, 3, 0, 3, 1'b0, "R4 src2 bypass");
    // R6: pool empty, offered group must not be taken
    rename(1, 2, 3, 4, 5, 6, 1'b0, "R6 stall");
    // R7: commit returns registers; one is not enough
    commit(4, 8, 4, 1'b0);
    rename(1, 2, 3, 4, 5, 6, 1'b0, "R6 stall one free");
    commit(5, 9, 5, 1'b0);
    // R6 R7 R9: stalled offers changed nothing; returned regs reused
    rename(6, 1, 7, 7, 4, 7, 1'b0, "R7 R9 reuse after commit");
    commit(6, 10, 6, 1'b0);
    // R8: flush with a group offered
    rename(1, 2, 3, 4, 5, 6, 1'b1, "R8 flush blocks");
    rename(4, 5, 0, 6, 7, 1, 1'b0, "R8 map after flush");
    // R8: commit and flush in one cycle
    commit(6, 11, 10, 1'b1);
    rename(6, 4, 2, 2, 6, 3, 1'b0, "R8 commit with flush");
    rename(0, 1, 5, 3, 5, 5, 1'b0, "R2 R5 after flush");
    repeat (2) @(posedge clk);
    check(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule